// File: doc/BRIEF.md
# Address Guard and System Register Block

This block sits between a processor's 16-bit byte address bus and its RAM. On every cycle it classifies the presented address, decides whether the requested read or write is permitted, and either lets the access through to RAM (or to the I/O window), serves it from a small set of system registers at the top of the address space, or declares a violation. A violation stops the machine. It also records an exit code that software or a debugger can read back afterwards.

The system registers are a writable 16-bit stack limit, a read-only copy of the highest RAM address (a build parameter), a free-running 16-bit tick counter and the exit-code byte. 16-bit values are stored with the high byte at the lower address. The block also stops the machine in two other cases: when the processor's stack-pointer pair reaches a non-zero stack limit, and when the processor signals a halt request with a reason code. Once stopped, the block accepts no further change of state. The system registers can still be read.

Top module: `sysreg_guard`

## Requirements
- R1: While reset is held, the tick count, the stack limit and the exit code read as 0x00 bytes and `halt_o` is low. Reads of 0xFFFB and 0xFFFC return the high and low bytes of the `MEM_TOP` parameter.
- R2: While running, a read or write to 0x0002..`MEM_TOP` or to 0xFF00..0xFF7F raises `ram_en_o` in the same cycle. For any other address `ram_en_o` stays low, and `rd_data_o` returns 0x00 for every address outside 0xFFF9..0xFFFF.
- R3: While running, the following accesses are violations:
  - any access to 0x0000, 0x0001, `MEM_TOP`+1..0xFEFF or 0xFF80..0xFFF8;
  - any write to 0xFFFB..0xFFFF.
  A violation keeps `ram_en_o` low in that cycle, raises `halt_o` from the next cycle, and sets the exit code to 0xFF.
- R4: A write to 0xFFF9 loads the high byte of the stack limit, and a write to 0xFFFA loads the low byte. Both take effect at the clock edge, and reads of the same addresses return the stored bytes.
- R5: While running, the tick count increases by one on every clock and wraps modulo 65536. 0xFFFD reads its high byte and 0xFFFE reads its low byte.
- R6: While running with a non-zero stack limit equal to `sp_i`, the block halts from the next cycle with exit code 0xFE. A limit of 0 never causes this.
- R7: A pulse on `end_req_i` while running halts the block from the next cycle and stores `end_code_i` as the exit code. A normal end uses 0x00.
- R8: When several stop causes occur in one cycle, the exit code follows this priority: violation (0xFF) first, then stack limit (0xFE), then the halt request.
- R9: Once halted, `halt_o` stays high until reset and the tick count is frozen. Writes to the stack limit are ignored, and `ram_en_o` stays low. No access creates a new exit code.
- R10: A read of 0xFFFF returns the stored exit code, both while running and after halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 16 | Byte address of the current access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| sp_i | input | 16 | Current stack-pointer pair |
| end_req_i | input | 1 | Processor halt request |
| end_code_i | input | 8 | Exit code stored with a halt request |
| rd_data_o | output | 8 | System register read data (0x00 outside 0xFFF9..0xFFFF) |
| ram_en_o | output | 1 | Access passes through to RAM or I/O |
| halt_o | output | 1 | Machine stopped |

## Verification
`ram_en_o` and `rd_data_o` are combinational from the address and the stored registers. The bench therefore drives inputs just after a falling edge and samples them one time unit later, in the same cycle. A register change caused by a write, a violation, a stack hit or a halt request appears only after the next rising edge. The bench checks such a result at the following falling edge, by sampling `halt_o` or by reading the affected register back through `rd_data_o`. The tick count is checked as a difference between two reads taken a known number of rising edges apart, including a span of exactly 65536 edges for the wrap.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] IO_LO   = 16'hFF00;
  localparam logic [AW-1:0] IO_HI   = 16'hFF7F;
  localparam logic [AW-1:0] LIM_HI  = 16'hFFF9;
  localparam logic [AW-1:0] LIM_LO  = 16'hFFFA;
  localparam logic [AW-1:0] MTOP_HI = 16'hFFFB;
  localparam logic [AW-1:0] MTOP_LO = 16'hFFFC;
  localparam logic [AW-1:0] TICK_HI = 16'hFFFD;
  localparam logic [AW-1:0] TICK_LO = 16'hFFFE;
  localparam logic [AW-1:0] EXIT_AD = 16'hFFFF;

  localparam logic [DW-1:0] CODE_VIOL  = 8'hFF;
  localparam logic [DW-1:0] CODE_STACK = 8'hFE;

  typedef enum logic [3:0] {
    RG_NULL, RG_RAM, RG_IO, RG_LIM_HI, RG_LIM_LO, RG_MTOP_HI,
    RG_MTOP_LO, RG_TICK_HI, RG_TICK_LO, RG_EXIT, RG_BAD
  } region_e;
endpackage

// File: rtl/sg_addr_decode.sv
module sg_addr_decode
  import sg_pkg::*;
#(
  parameter logic [15:0] MEM_TOP = 16'h0FFF
) (
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          running_i,
  output region_e       region_o,
  output logic          fault_o,
  output logic          ram_en_o,
  output logic          lim_wr_hi_o,
  output logic          lim_wr_lo_o
);
  logic access;
  logic writable;
  logic illegal;

  always_comb begin
    region_o = RG_BAD;
    if (addr_i < 16'd2)                            region_o = RG_NULL;
    else if (addr_i <= MEM_TOP)                    region_o = RG_RAM;
    else if (addr_i >= IO_LO && addr_i <= IO_HI)   region_o = RG_IO;
    else begin
      case (addr_i)
        LIM_HI:  region_o = RG_LIM_HI;
        LIM_LO:  region_o = RG_LIM_LO;
        MTOP_HI: region_o = RG_MTOP_HI;
        MTOP_LO: region_o = RG_MTOP_LO;
        TICK_HI: region_o = RG_TICK_HI;
        TICK_LO: region_o = RG_TICK_LO;
        EXIT_AD: region_o = RG_EXIT;
        default: region_o = RG_BAD;
      endcase
    end
  end

  always_comb begin
    access   = rd_i | wr_i;
    writable = (region_o == RG_RAM) || (region_o == RG_IO) ||
               (region_o == RG_LIM_HI) || (region_o == RG_LIM_LO);
    illegal  = (region_o == RG_NULL) || (region_o == RG_BAD) ||
               (wr_i && !writable);
    fault_o     = running_i && access && illegal;
    ram_en_o    = running_i && access &&
                  ((region_o == RG_RAM) || (region_o == RG_IO));
    lim_wr_hi_o = running_i && wr_i && (region_o == RG_LIM_HI);
    lim_wr_lo_o = running_i && wr_i && (region_o == RG_LIM_LO);
  end
endmodule

// File: rtl/sg_state.sv
module sg_state
  import sg_pkg::*;
#(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              lim_wr_hi_i,
  input  logic              lim_wr_lo_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [AW-1:0]     sp_i,
  input  logic              end_req_i,
  input  logic [DW-1:0]     end_code_i,
  output logic              running_o,
  output logic              stopped_o,
  output logic [TICK_W-1:0] tick_o,
  output logic [AW-1:0]     limit_o,
  output logic [DW-1:0]     exit_o
);
  logic              stopped_q, stopped_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [AW-1:0]     limit_q, limit_d;
  logic [DW-1:0]     exit_q, exit_d;
  logic              stack_hit;
  logic              stop_now;
  logic              running;

  always_comb begin
    running   = !stopped_q;
    stack_hit = running && (limit_q != '0) && (sp_i == limit_q);
    stop_now  = running && (fault_i || stack_hit || end_req_i);

    tick_d    = running ? tick_q + 1'b1 : tick_q;
    stopped_d = stopped_q | stop_now;

    limit_d = limit_q;
    if (running && lim_wr_hi_i) limit_d[AW-1:DW] = wdata_i;
    if (running && lim_wr_lo_i) limit_d[DW-1:0]  = wdata_i;

    exit_d = exit_q;
    if (running) begin
      if (fault_i)        exit_d = CODE_VIOL;
      else if (stack_hit) exit_d = CODE_STACK;
      else if (end_req_i) exit_d = end_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_q <= 1'b0;
      tick_q    <= '0;
      limit_q   <= '0;
      exit_q    <= '0;
    end else begin
      stopped_q <= stopped_d;
      tick_q    <= tick_d;
      limit_q   <= limit_d;
      exit_q    <= exit_d;
    end
  end

  assign running_o = running;
  assign stopped_o = stopped_q;
  assign tick_o    = tick_q;
  assign limit_o   = limit_q;
  assign exit_o    = exit_q;

  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    stopped_q |=> stopped_q);

  // R5
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !stopped_q |=> tick_q == $past(tick_q) + 1'b1);

  // R9
  tick_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    stopped_q |=> $stable(tick_q) && $stable(limit_q) && $stable(exit_q));

  // R6
  stack_code_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!stopped_q && !fault_i && limit_q != '0 && sp_i == limit_q)
      |=> stopped_q && exit_q == CODE_STACK);
endmodule

// File: rtl/sg_rdmux.sv
module sg_rdmux
  import sg_pkg::*;
#(
  parameter logic [15:0] MEM_TOP = 16'h0FFF,
  parameter int unsigned TICK_W  = 16
) (
  input  region_e           region_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [AW-1:0]     limit_i,
  input  logic [DW-1:0]     exit_i,
  output logic [DW-1:0]     rd_data_o
);
  localparam int unsigned TPAD = 2 * DW;
  logic [TPAD-1:0] tick_w;

  always_comb begin
    tick_w = TPAD'(tick_i);
    unique case (region_i)
      RG_LIM_HI:  rd_data_o = limit_i[AW-1:DW];
      RG_LIM_LO:  rd_data_o = limit_i[DW-1:0];
      RG_MTOP_HI: rd_data_o = MEM_TOP[AW-1:DW];
      RG_MTOP_LO: rd_data_o = MEM_TOP[DW-1:0];
      RG_TICK_HI: rd_data_o = tick_w[TPAD-1:DW];
      RG_TICK_LO: rd_data_o = tick_w[DW-1:0];
      RG_EXIT:    rd_data_o = exit_i;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/sysreg_guard.sv
module sysreg_guard
  import sg_pkg::*;
#(
  parameter logic [15:0] MEM_TOP = 16'h0FFF,
  parameter int unsigned TICK_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  input  logic [15:0] sp_i,
  input  logic        end_req_i,
  input  logic [7:0]  end_code_i,
  output logic [7:0]  rd_data_o,
  output logic        ram_en_o,
  output logic        halt_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  region_e           region;
  logic              fault;
  logic              lim_wr_hi, lim_wr_lo;
  logic              running, stopped;
  logic [TICK_W-1:0] tick;
  logic [AW-1:0]     limit;
  logic [DW-1:0]     exit_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sg_addr_decode #(.MEM_TOP(MEM_TOP)) u_dec (
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .running_i   (running),
    .region_o    (region),
    .fault_o     (fault),
    .ram_en_o    (ram_en_o),
    .lim_wr_hi_o (lim_wr_hi),
    .lim_wr_lo_o (lim_wr_lo)
  );

  sg_state #(.TICK_W(TICK_W)) u_state (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .fault_i     (fault),
    .lim_wr_hi_i (lim_wr_hi),
    .lim_wr_lo_i (lim_wr_lo),
    .wdata_i     (wdata_i),
    .sp_i        (sp_i),
    .end_req_i   (end_req_i),
    .end_code_i  (end_code_i),
    .running_o   (running),
    .stopped_o   (stopped),
    .tick_o      (tick),
    .limit_o     (limit),
    .exit_o      (exit_code)
  );

  sg_rdmux #(.MEM_TOP(MEM_TOP), .TICK_W(TICK_W)) u_mux (
    .region_i  (region),
    .tick_i    (tick),
    .limit_i   (limit),
    .exit_i    (exit_code),
    .rd_data_o (rd_data_o)
  );

  assign halt_o = stopped;

  // R3
  viol_halt_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!halt_o && fault) |=> halt_o && exit_code == CODE_VIOL);

  // R3
  viol_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fault |-> !ram_en_o);

  // R9
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    halt_o |-> !ram_en_o && !fault);

  // R4
  lim_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!halt_o && wr_i && addr_i == LIM_HI) |=> limit[AW-1:DW] == $past(wdata_i));
endmodule

// File: tb/sysreg_guard_tb_top.sv
module sysreg_guard_tb_top;
  localparam logic [15:0] MEM_TOP = 16'h0FFF;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        rd, wr;
  logic [7:0]  wdata;
  logic [15:0] sp;
  logic        end_req;
  logic [7:0]  end_code;
  logic [7:0]  rd_data;
  logic        ram_en, halt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysreg_guard #(.MEM_TOP(MEM_TOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .sp_i(sp), .end_req_i(end_req), .end_code_i(end_code),
    .rd_data_o(rd_data), .ram_en_o(ram_en), .halt_o(halt)
  );

  // vector table: address, read, write, expected ram_en, expected rd_data (R2)
  localparam logic [15:0] V_ADDR [NV] = '{16'h0002, MEM_TOP, 16'h0800, 16'hFF00,
    16'hFF7F, 16'hFFFB, 16'hFFFC, 16'hFFFF, 16'hFFF9, 16'h0000};
  localparam logic V_RD [NV] = '{1, 0, 1, 1, 0, 1, 1, 1, 1, 0};
  localparam logic V_WR [NV] = '{0, 1, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam logic V_EN [NV] = '{1, 1, 1, 1, 1, 0, 0, 0, 0, 0};
  localparam logic [7:0] V_DAT [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    MEM_TOP[15:8], MEM_TOP[7:0], 8'h00, 8'h00, 8'h00};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d; end_req = 1'b0;
    #1;
  endtask

  task automatic idle();
    drive(16'hFFFF, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic rd16(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1; wr = 1'b0; #1; v[15:8] = rd_data;
    addr = a + 16'd1; #1; v[7:0] = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; addr = 16'hFFFF; rd = 0; wr = 0; wdata = 0; sp = 0;
    end_req = 0; end_code = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic viol_case(input string req, input logic [15:0] a, input logic w);
    do_reset();
    drive(a, !w, w, 8'h5A);
    chk({req, " ram_en blocked"}, 16'(ram_en), 16'h0);
    idle();
    chk({req, " halt"}, 16'(halt), 16'h1);
    drive(16'hFFFF, 1'b1, 1'b0, 8'h00);
    chk({req, " exit FF"}, 16'(rd_data), 16'h00FF);
  endtask

  initial begin
    logic [15:0] t0, t1, v;
    rst_n = 1'b0; addr = 16'hFFFF; rd = 0; wr = 0; wdata = 0; sp = 0;
    end_req = 0; end_code = 0;

    // R1 reset state while reset held
    repeat (2) @(negedge clk);
    rd16(16'hFFFD, v); chk("R1 tick", v, 16'h0000);
    rd16(16'hFFF9, v); chk("R1 limit", v, 16'h0000);
    drive(16'hFFFF, 1, 0, 0); chk("R1 exit", 16'(rd_data), 16'h0);
    chk("R1 halt", 16'(halt), 16'h0);
    rd16(16'hFFFB, v); chk("R1 mem top", v, MEM_TOP);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 table
    for (int i = 0; i < NV; i++) begin
      drive(V_ADDR[i], V_RD[i], V_WR[i], 8'h33);
      chk($sformatf("R2 vec%0d ram_en", i), 16'(ram_en), 16'(V_EN[i]));
      chk($sformatf("R2 vec%0d rd_data", i), 16'(rd_data), 16'(V_DAT[i]));
    end
    idle();
    chk("R2 no halt after legal", 16'(halt), 16'h0);
    // R10 exit readable while running
    drive(16'hFFFF, 1, 0, 0); chk("R10 exit running", 16'(rd_data), 16'h0);

    // R5 tick step and wrap
    rd16(16'hFFFD, t0);
    repeat (4) @(negedge clk);
    rd16(16'hFFFD, t1);
    chk("R5 tick +5", t1 - t0, 16'd5);
    rd16(16'hFFFD, t0);
    repeat (65535) @(negedge clk);
    rd16(16'hFFFD, t1);
    chk("R5 tick wrap", t1, t0);

    // R4 limit write/read, R6 limit zero
    idle();
    chk("R6 zero limit no halt", 16'(halt), 16'h0);
    drive(16'hFFF9, 0, 1, 8'h01);
    drive(16'hFFFA, 0, 1, 8'h23);
    rd16(16'hFFF9, v); chk("R4 limit readback", v, 16'h0123);
    sp = 16'h0122; idle(); idle();
    chk("R6 below limit", 16'(halt), 16'h0);
    sp = 16'h0123; idle();
    chk("R6 stack halt", 16'(halt), 16'h1);
    drive(16'hFFFF, 1, 0, 0); chk("R6 exit FE", 16'(rd_data), 16'h00FE);

    // R3 violations
    viol_case("R3 null", 16'h0000, 1'b0);
    viol_case("R3 addr1", 16'h0001, 1'b1);
    viol_case("R3 above ram", MEM_TOP + 16'd1, 1'b0);
    viol_case("R3 reserved", 16'hFF80, 1'b0);
    viol_case("R3 write tick", 16'hFFFD, 1'b1);
    viol_case("R3 write exit", 16'hFFFF, 1'b1);

    // R7 end request
    do_reset();
    @(negedge clk); end_req = 1; end_code = 8'h42; #1;
    idle();
    chk("R7 end halt", 16'(halt), 16'h1);
    drive(16'hFFFF, 1, 0, 0); chk("R7 exit code", 16'(rd_data), 16'h0042);
    // R9 frozen after halt
    drive(16'hFFF9, 0, 1, 8'h55);
    rd16(16'hFFF9, v); chk("R9 limit write ignored", v, 16'h0000);
    drive(16'h0002, 1, 0, 0); chk("R9 ram_en low", 16'(ram_en), 16'h0);
    drive(16'h0000, 1, 0, 0); idle();
    drive(16'hFFFF, 1, 0, 0); chk("R9 exit unchanged", 16'(rd_data), 16'h0042);
    rd16(16'hFFFD, t0); repeat (4) @(negedge clk); rd16(16'hFFFD, t1);
    chk("R9 tick frozen", t1, t0);
    chk("R9 halt held", 16'(halt), 16'h1);

    // R8 priority: violation over stack over end
    do_reset();
    drive(16'hFFFA, 0, 1, 8'h10);
    sp = 16'h0010;
    @(negedge clk); addr = 16'h0000; rd = 1; end_req = 1; end_code = 8'h00; #1;
    idle();
    drive(16'hFFFF, 1, 0, 0); chk("R8 violation first", 16'(rd_data), 16'h00FF);
    do_reset();
    drive(16'hFFFA, 0, 1, 8'h10);
    @(negedge clk);
    sp = 16'h0010; end_req = 1; end_code = 8'h00; addr = 16'hFFFF; rd = 0; wr = 0; #1;
    idle();
    drive(16'hFFFF, 1, 0, 0); chk("R8 stack over end", 16'(rd_data), 16'h00FE);
    // R7 normal end code 0x00
    do_reset();
    @(negedge clk); end_req = 1; end_code = 8'h00; #1;
    idle();
    chk("R7 normal end halt", 16'(halt), 16'h1);
    drive(16'hFFFF, 1, 0, 0); chk("R7 normal end code", 16'(rd_data), 16'h0000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule